// File: doc/BRIEF.md
# Handshaked Dual-SRAM Control Sequencer

This block stands between a host and two small asynchronous static RAM chips that share one data bus. The host presents a five-bit address and a read/write flag, then raises a request strobe. The sequencer produces the active-low chip-select, write-enable and output-enable lines for each chip. For reads it also produces an active-low enable for the buffer that carries RAM data back to the host. It raises an acknowledge when the transfer is done. The top address bit picks the chip. The low four address bits go straight through to both chips.

Request and acknowledge form a four-phase handshake. The host raises request once its address (and, for a write, its data) is stable. The block raises acknowledge when read data is on the bus or the write strobe has been applied. The host drops request once it has taken the data. The block then releases the RAM strobes one at a time and drops acknowledge only after every strobe is back high. Only then may the host change the address. The request line is treated as asynchronous and passes through a flop synchronizer. Every step of each strobe order lasts one clock. There is no data stream here, so no valid/ready channel and no back-pressure: request and acknowledge are plain level pins, and the host itself holds the address and flag stable until acknowledge falls.

Top module: `sram_pair_sequencer`

## Requirements
- R1: While reset is low and after it is released with no request, every chip-select, write-enable and output-enable, and the buffer enable, is high, and acknowledge is low.
- R2: For a read (host_wr = 0), the selected chip's output-enable goes low first. Its chip-select goes low one clock later. One clock after that, acknowledge rises and the buffer enable goes low.
- R3: After request falls on a read, the selected chip-select and the buffer enable return high first. Output-enable returns high one clock later, and acknowledge falls one clock after that.
- R4: For a write (host_wr = 1), output-enable stays high throughout. The selected chip-select goes low first, write-enable goes low one clock later, and acknowledge rises one clock after that.
- R5: After request falls on a write, write-enable returns high first. Chip-select returns high one clock later, and acknowledge falls one clock after that.
- R6: host_addr[4] = 0 selects chip index 0 and host_addr[4] = 1 selects chip index 1. host_addr[3:0] appears unchanged on ram_addr.
- R7: At most one output-enable is low at any time, and the chip that is not selected keeps all three of its strobes high during a transfer.
- R8: Acknowledge stays high for as long as request stays high. When acknowledge falls, every RAM strobe was already high in the previous clock.
- R9: A request edge takes effect through a two-flop synchronizer. The first strobe moves on the third rising clock edge after request rises, and on the third edge after it falls.
- R10: The chip selection and the read/write flag are captured when a request is accepted. Changes to host_addr[4] or host_wr later in the same transfer have no effect on the strobes.
- R11: The buffer enable is low only while acknowledge is high and an output-enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Asynchronous transfer request from the host |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Bit 4 selects the chip, bits 3:0 the location |
| host_ack | output | 1 | Transfer acknowledge to the host |
| buf_en_n | output | 1 | Active-low enable of the host-side read buffer |
| ram_addr | output | 4 | Location address to both chips |
| ram_cs_n | output | 2 | Active-low chip-select, one bit per chip |
| ram_we_n | output | 2 | Active-low write-enable, one bit per chip |
| ram_oe_n | output | 2 | Active-low output-enable, one bit per chip |

## Verification
All strobe outputs are registered. A request edge therefore shows on the pins on the third rising edge after it is driven: two edges in the synchronizer and one in the state and output register. Each later ordering step follows exactly one edge later. The bench drives inputs on falling edges and samples one falling edge after each rising edge. It compares the full strobe bundle against the expected value for that step count, five steps after a request rises and five after it falls. A transfer is run for every address and both directions. During the hold phase the chip bit and the direction flag are flipped to show that the outputs do not move.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_OE,
    ST_RD_CS,
    ST_RD_ACK,
    ST_RD_DROP,
    ST_WR_CS,
    ST_WR_WE,
    ST_WR_ACK,
    ST_WR_DROP,
    ST_RELEASE
  } seq_state_t;

  // Active-high internal strobe set, one per state.
  typedef struct packed {
    logic sel;
    logic wen;
    logic oen;
    logic ack;
    logic bufen;
  } strobe_t;

  localparam strobe_t STROBE_NONE = '{sel: 1'b0, wen: 1'b0, oen: 1'b0, ack: 1'b0, bufen: 1'b0};

  function automatic strobe_t strobes_of(seq_state_t s);
    strobe_t r;
    r = STROBE_NONE;
    case (s)
      ST_RD_OE:   begin r.oen = 1'b1; end
      ST_RD_CS:   begin r.oen = 1'b1; r.sel = 1'b1; end
      ST_RD_ACK:  begin r.oen = 1'b1; r.sel = 1'b1; r.ack = 1'b1; r.bufen = 1'b1; end
      ST_RD_DROP: begin r.oen = 1'b1; r.ack = 1'b1; end
      ST_WR_CS:   begin r.sel = 1'b1; end
      ST_WR_WE:   begin r.sel = 1'b1; r.wen = 1'b1; end
      ST_WR_ACK:  begin r.sel = 1'b1; r.wen = 1'b1; r.ack = 1'b1; end
      ST_WR_DROP: begin r.sel = 1'b1; r.ack = 1'b1; end
      ST_RELEASE: begin r.ack = 1'b1; end
      default:    r = STROBE_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sps_req_sync.sv
module sps_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/sps_seq_fsm.sv
module sps_seq_fsm
  import sps_pkg::*;
#(
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  input  logic              wr_in,
  input  logic [BANK_W-1:0] bank_in,
  output strobe_t           strb_nx,
  output logic [BANK_W-1:0] bank_nx
);
  seq_state_t        state_q, state_d;
  logic [BANK_W-1:0] bank_q;

  always_comb begin
    state_d = state_q;
    bank_nx = bank_q;
    case (state_q)
      ST_IDLE: if (req_s) begin
        bank_nx = bank_in;
        state_d = wr_in ? ST_WR_CS : ST_RD_OE;
      end
      ST_RD_OE:   state_d = ST_RD_CS;
      ST_RD_CS:   state_d = ST_RD_ACK;
      ST_RD_ACK:  if (!req_s) state_d = ST_RD_DROP;
      ST_RD_DROP: state_d = ST_RELEASE;
      ST_WR_CS:   state_d = ST_WR_WE;
      ST_WR_WE:   state_d = ST_WR_ACK;
      ST_WR_ACK:  if (!req_s) state_d = ST_WR_DROP;
      ST_WR_DROP: state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    strb_nx = strobes_of(state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bank_q  <= '0;
    end else begin
      state_q <= state_d;
      bank_q  <= bank_nx;
    end
  end

  // R8: while the host still requests, the acknowledge phase is held
  assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RD_ACK || state_q == ST_WR_ACK) && req_s) |=> strobes_of(state_q).ack);

  // R10: chip choice only moves when a new request is accepted from idle
  assert_bank_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(bank_q));
endmodule

// File: rtl/sps_bank_demux.sv
module sps_bank_demux
  import sps_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  strobe_t                strb,
  input  logic [BANK_W-1:0]      bank,
  output logic [NUM_BANKS-1:0]   cs_n,
  output logic [NUM_BANKS-1:0]   we_n,
  output logic [NUM_BANKS-1:0]   oe_n,
  output logic                   buf_n
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit;
    assign hit     = (bank == BANK_W'(i));
    assign cs_n[i] = ~(hit & strb.sel);
    assign we_n[i] = ~(hit & strb.wen);
    assign oe_n[i] = ~(hit & strb.oen);
  end

  assign buf_n = ~strb.bufen;
endmodule

// File: rtl/sram_pair_sequencer.sv
module sram_pair_sequencer
  import sps_pkg::*;
#(
  parameter  int LOC_W       = 4,
  parameter  int NUM_BANKS   = 2,
  parameter  int SYNC_STAGES = 2,
  localparam int BANK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W      = LOC_W + BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_req,
  input  logic                 host_wr,
  input  logic [ADDR_W-1:0]    host_addr,
  output logic                 host_ack,
  output logic                 buf_en_n,
  output logic [LOC_W-1:0]     ram_addr,
  output logic [NUM_BANKS-1:0] ram_cs_n,
  output logic [NUM_BANKS-1:0] ram_we_n,
  output logic [NUM_BANKS-1:0] ram_oe_n
);
  logic              req_s;
  strobe_t           strb_nx;
  logic [BANK_W-1:0] bank_nx;
  logic [NUM_BANKS-1:0] cs_d, we_d, oe_d;
  logic              buf_d;

  assign ram_addr = host_addr[LOC_W-1:0];

  sps_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(host_req), .sync_out(req_s)
  );

  sps_seq_fsm #(.BANK_W(BANK_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .wr_in(host_wr),
    .bank_in(host_addr[ADDR_W-1 -: BANK_W]),
    .strb_nx(strb_nx), .bank_nx(bank_nx)
  );

  sps_bank_demux #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_demux (
    .strb(strb_nx), .bank(bank_nx),
    .cs_n(cs_d), .we_n(we_d), .oe_n(oe_d), .buf_n(buf_d)
  );

  // Glitch-free strobes: every pin comes straight from a flop.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_cs_n <= '1;
      ram_we_n <= '1;
      ram_oe_n <= '1;
      buf_en_n <= 1'b1;
      host_ack <= 1'b0;
    end else begin
      ram_cs_n <= cs_d;
      ram_we_n <= we_d;
      ram_oe_n <= oe_d;
      buf_en_n <= buf_d;
      host_ack <= strb_nx.ack;
    end
  end

  assert_single_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ram_oe_n));

  assert_buf_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en_n |-> (host_ack && (ram_oe_n != '1)));

  assert_ack_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_ack) |-> ($past(&ram_cs_n) && $past(&ram_we_n) && $past(&ram_oe_n)));

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_chk
    assert_write_no_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n[i] |-> (ram_oe_n[i] && !ram_cs_n[i]));

    assert_we_after_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_we_n[i]) |-> $past(!ram_cs_n[i]));

    assert_cs_after_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ram_cs_n[i]) && !ram_oe_n[i]) |-> $past(!ram_oe_n[i]));

    assert_cs_before_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_oe_n[i]) |-> $past(ram_cs_n[i]));
  end
endmodule

// File: tb/sram_pair_sequencer_tb.sv
module sram_pair_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_req = 1'b0;
  logic       host_wr = 1'b0;
  logic [4:0] host_addr = '0;
  logic       host_ack, buf_en_n;
  logic [3:0] ram_addr;
  logic [1:0] ram_cs_n, ram_we_n, ram_oe_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  sram_pair_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_ack(host_ack), .buf_en_n(buf_en_n),
    .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected active set {oe,cs,we,ack,buf} at step k after a request edge.
  function automatic logic [4:0] phase_of(bit wr, bit rising, int k);
    if (rising) begin
      if (k <= 2) return 5'b00000;
      if (!wr) return (k == 3) ? 5'b10000 : (k == 4) ? 5'b11000 : 5'b11011;
      return (k == 3) ? 5'b01000 : (k == 4) ? 5'b01100 : 5'b01110;
    end
    if (k <= 2) return wr ? 5'b01110 : 5'b11011;
    if (!wr) return (k == 3) ? 5'b10010 : (k == 4) ? 5'b00010 : 5'b00000;
    return (k == 3) ? 5'b01010 : (k == 4) ? 5'b00010 : 5'b00000;
  endfunction

  task automatic check_bus(string tag, logic [4:0] ph, int bank);
    logic [7:0] exp_v, got_v;
    logic [1:0] cs, we, oe;
    cs = 2'b11; we = 2'b11; oe = 2'b11;
    if (ph[3]) cs[bank] = 1'b0;
    if (ph[2]) we[bank] = 1'b0;
    if (ph[4]) oe[bank] = 1'b0;
    exp_v = {ph[1], ~ph[0], cs, we, oe};
    got_v = {host_ack, buf_en_n, ram_cs_n, ram_we_n, ram_oe_n};
    n_tests++;
    if (got_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s addr=%0d: got {ack,buf_n,cs_n,we_n,oe_n}=%b expected %b",
               tag, host_addr, got_v, exp_v);
    end
  endtask

  task automatic run_xfer(logic [4:0] addr, bit wr);
    int bank = int'(addr[4]);
    host_addr = addr;
    host_wr   = wr;
    host_req  = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      step();
      if (k <= 2)      check_bus("R9 sync delay on rise", phase_of(wr, 1, k), bank);
      else if (!wr)    check_bus("R2 R11 read order", phase_of(wr, 1, k), bank);
      else             check_bus("R4 write order", phase_of(wr, 1, k), bank);
    end
    // R6: location bits pass through; R7: only the chosen chip is touched
    n_tests++;
    if (ram_addr !== addr[3:0]) begin
      n_fail++;
      $display("FAIL R6 ram_addr got %0d expected %0d", ram_addr, addr[3:0]);
    end
    n_tests++;
    if ({ram_cs_n[1-bank], ram_we_n[1-bank], ram_oe_n[1-bank]} !== 3'b111) begin
      n_fail++;
      $display("FAIL R7 idle chip %0d strobes got %b expected 111", 1-bank,
               {ram_cs_n[1-bank], ram_we_n[1-bank], ram_oe_n[1-bank]});
    end
    // R10: flip chip bit and direction mid-transfer; R8: ack held
    host_addr[4] = ~addr[4];
    host_wr      = ~wr;
    for (int k = 0; k < 3; k++) begin
      step();
      check_bus("R8 R10 hold with changed inputs", phase_of(wr, 1, 5), bank);
    end
    host_req = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      step();
      if (k <= 2)   check_bus("R9 sync delay on fall", phase_of(wr, 0, k), bank);
      else if (!wr) check_bus("R3 R10 read release", phase_of(wr, 0, k), bank);
      else          check_bus("R5 R10 write release", phase_of(wr, 0, k), bank);
    end
    host_addr = addr;
    host_wr   = wr;
    step();
  endtask

  initial begin
    @(negedge clk);
    check_bus("R1 reset state", 5'b00000, 0);
    step();
    check_bus("R1 reset state held", 5'b00000, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      check_bus("R1 idle after reset", 5'b00000, 0);
    end
    for (int a = 0; a < 32; a++) begin
      run_xfer(5'(a), 1'b1);
      run_xfer(5'(a), 1'b0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule